// File: doc/BRIEF.md
# Time-Code Frame Capture and Serial Readout

The block receives one symbol per second from an upstream pulse-width demodulator. Each symbol is classified as a zero, a one or a marker. Over one 60-second minute it keeps the 53 data symbols, counts the markers and checks where they fall. When the sixtieth symbol is accepted, it raises a ready line to an external microcontroller and drives the whole frame out as a serial master.

The serial link uses an active-low select that frames the transfer. The serial clock idles low and is derived from the system clock. The receiver samples on rising edges, and the block changes its data bit on falling edges. The frame leaves in fully reversed order, so the bit captured last goes out first. Capture is frozen while a frame is pending. It restarts at second 0 once the transfer has finished and ready has dropped.

Top module: `tcf_readout`

## Requirements
- R1: While reset is held, ready_o is 0, spi_csn_o is 1, spi_sclk_o is 0, spi_sdo_o is 0, and both validation flags are 0.
- R2: Symbol encoding on sym_i is 0 for zero, 1 for one, 2 for marker, and 3 is treated as zero. A symbol is accepted on a clock edge where sym_valid_i is 1, and cycles with sym_valid_i at 0 have no effect. The first accepted symbol of a minute is second 0. Seconds 0 and every second whose index modulo 10 equals 9 are marker slots. The other 53 seconds are data slots, and each stores 1 exactly when its symbol is a one, in arrival order.
- R3: ready_o rises on the clock edge that accepts the 60th symbol. It stays high for the whole transfer and falls on the same edge on which spi_csn_o returns high.
- R4: The serial stream carries the 53 stored bits in reverse capture order: the last data slot of the minute goes first and the first data slot goes last.
- R5: spi_sclk_o idles at 0. Its high and low phases each last CLK_DIV_HALF system clocks. spi_sdo_o changes only at falling edges of spi_sclk_o, so it is stable while the clock is high.
- R6: spi_csn_o falls on the edge that accepts the 60th symbol. It stays low for exactly 53 rising edges of spi_sclk_o. Whenever spi_csn_o is high, spi_sclk_o and spi_sdo_o are 0.
- R7: cnt_ok_o is 1 exactly when the minute held exactly 7 marker symbols. It is updated on the edge on which ready_o rises and holds its value until the next minute completes.
- R8: pos_ok_o is 1 exactly when every marker slot held a marker and no data slot held one. It is updated and held in the same way as cnt_ok_o.
- R9: Symbols presented while ready_o is high are ignored. The next minute is built only from symbols accepted after ready_o has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | One-cycle strobe for a new second symbol |
| sym_i | input | 2 | Symbol class: 0 zero, 1 one, 2 marker, 3 zero |
| ready_o | output | 1 | Frame pending for the microcontroller |
| cnt_ok_o | output | 1 | Marker count check passed |
| pos_ok_o | output | 1 | Marker position check passed |
| spi_csn_o | output | 1 | Serial select, active low |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_sdo_o | output | 1 | Serial data out |

## Verification
The bench builds the block with FRAME_SLOTS at 60 and CLK_DIV_HALF at 3. The odd half-period shows whether the divider counts phases exactly, and it keeps each transfer to a few hundred cycles, so many minutes fit in one run. The minutes cover random data, all ones, all zeros, the reserved symbol code, a missing marker, a displaced marker and an extra marker. Together these reach every combination of the two flags that can occur. Random gaps between symbols exercise the valid strobe, and junk symbols fed during pending transfers confirm that capture stays frozen.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_MARK = 2'd2,
    SYM_RSVD = 2'd3
  } sym_e;

  // marker slots: second 0 and every second ending in 9
  function automatic logic is_mark_slot(input int unsigned sec);
    return (sec == 0) || (sec % 10 == 9);
  endfunction
endpackage

// File: rtl/tcf_capture.sv
module tcf_capture
  import tcf_pkg::*;
#(
  parameter int unsigned FRAME_SLOTS = 60,
  parameter int unsigned MARKS       = 7,
  parameter int unsigned DATA_BITS   = 53
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hold_i,
  input  logic                 sym_valid_i,
  input  logic [1:0]           sym_i,
  output logic [DATA_BITS-1:0] frame_o,
  output logic                 cnt_ok_o,
  output logic                 pos_ok_o,
  output logic                 done_o
);
  localparam int unsigned SW = $clog2(FRAME_SLOTS);
  localparam int unsigned CW = $clog2(FRAME_SLOTS + 1);

  logic [SW-1:0]        slot_q;
  logic [CW-1:0]        mcnt_q, mcnt_nxt;
  logic                 pos_q, pos_nxt;
  logic [DATA_BITS-1:0] frame_q;
  logic                 cnt_ok_q, pos_ok_q;
  logic                 accept, last, exp_mark, got_mark;
  sym_e                 sym;

  always_comb begin
    sym      = sym_e'(sym_i);
    accept   = sym_valid_i && !hold_i;
    last     = (slot_q == SW'(FRAME_SLOTS - 1));
    exp_mark = is_mark_slot(32'(slot_q));
    got_mark = (sym == SYM_MARK);
    mcnt_nxt = mcnt_q + CW'(got_mark);
    pos_nxt  = pos_q && (got_mark == exp_mark);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      mcnt_q   <= '0;
      pos_q    <= 1'b1;
      frame_q  <= '0;
      cnt_ok_q <= 1'b0;
      pos_ok_q <= 1'b0;
    end else if (accept) begin
      if (!exp_mark) frame_q <= {frame_q[DATA_BITS-2:0], sym == SYM_ONE};
      if (last) begin
        slot_q   <= '0;
        mcnt_q   <= '0;
        pos_q    <= 1'b1;
        cnt_ok_q <= (mcnt_nxt == CW'(MARKS));
        pos_ok_q <= pos_nxt;
      end else begin
        slot_q <= slot_q + 1'b1;
        mcnt_q <= mcnt_nxt;
        pos_q  <= pos_nxt;
      end
    end
  end

  assign frame_o  = frame_q;
  assign cnt_ok_o = cnt_ok_q;
  assign pos_ok_o = pos_ok_q;
  assign done_o   = accept && last;

  assert_slot_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < SW'(FRAME_SLOTS));
  assert_flags_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(cnt_ok_q) && $stable(pos_ok_q));
  assert_pos_needs_cnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_ok_q |-> cnt_ok_q);
  assert_frozen_on_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(frame_q) && $stable(slot_q));
endmodule

// File: rtl/tcf_tick.sv
module tcf_tick #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tcf_spi_tx.sv
module tcf_spi_tx #(
  parameter int unsigned DATA_BITS = 53,
  parameter int unsigned HALF      = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DATA_BITS-1:0] frame_i,
  output logic                 csn_o,
  output logic                 sclk_o,
  output logic                 sdo_o,
  output logic                 done_o
);
  localparam int unsigned IW = $clog2(DATA_BITS);

  logic          busy_q, tail_q, sclk_q, tick;
  logic [IW-1:0] idx_q;

  tcf_tick #(.HALF(HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tail_q <= 1'b0;
      sclk_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      tail_q <= 1'b0;
      sclk_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q && tick) begin
      if (tail_q) begin
        busy_q <= 1'b0;  // half period of hold after last fall
        tail_q <= 1'b0;
      end else if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        if (idx_q == IW'(DATA_BITS - 1)) tail_q <= 1'b1;
        else                             idx_q  <= idx_q + 1'b1;
      end
    end
  end

  // frame_i is frozen while busy; index walks from the last captured bit
  assign sdo_o  = busy_q && frame_i[idx_q];
  assign csn_o  = !busy_q;
  assign sclk_o = sclk_q;
  assign done_o = busy_q && tick && tail_q;

  assert_idle_clk_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  assert_shift_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && (idx_q != $past(idx_q))) |-> $fell(sclk_q));
  assert_tail_clk_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q |-> !sclk_q && busy_q);
endmodule

// File: rtl/tcf_readout.sv
module tcf_readout #(
  parameter int unsigned FRAME_SLOTS  = 60,
  parameter int unsigned CLK_DIV_HALF = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_valid_i,
  input  logic [1:0] sym_i,
  output logic       ready_o,
  output logic       cnt_ok_o,
  output logic       pos_ok_o,
  output logic       spi_csn_o,
  output logic       spi_sclk_o,
  output logic       spi_sdo_o
);
  localparam int unsigned MARKS     = 1 + FRAME_SLOTS / 10;
  localparam int unsigned DATA_BITS = FRAME_SLOTS - MARKS;

  logic [DATA_BITS-1:0] frame;
  logic                 cap_done, tx_done, ready_q;

  tcf_capture #(
    .FRAME_SLOTS (FRAME_SLOTS),
    .MARKS       (MARKS),
    .DATA_BITS   (DATA_BITS)
  ) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (ready_q),
    .sym_valid_i (sym_valid_i),
    .sym_i       (sym_i),
    .frame_o     (frame),
    .cnt_ok_o    (cnt_ok_o),
    .pos_ok_o    (pos_ok_o),
    .done_o      (cap_done)
  );

  tcf_spi_tx #(
    .DATA_BITS (DATA_BITS),
    .HALF      (CLK_DIV_HALF)
  ) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cap_done),
    .frame_i (frame),
    .csn_o   (spi_csn_o),
    .sclk_o  (spi_sclk_o),
    .sdo_o   (spi_sdo_o),
    .done_o  (tx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ready_q <= 1'b0;
    else if (cap_done) ready_q <= 1'b1;
    else if (tx_done)  ready_q <= 1'b0;
  end

  assign ready_o = ready_q;

  assert_select_within_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_csn_o |-> ready_o);
  assert_ready_drop_with_csn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $rose(spi_csn_o));
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_csn_o |-> !spi_sclk_o && !spi_sdo_o);
endmodule

// File: tb/tcf_readout_tb_top.sv
module tcf_readout_tb_top;
  localparam int SLOTS = 60;
  localparam int NBITS = 53;
  localparam int HALF  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym = 2'd0;
  logic       ready, cnt_ok, pos_ok, csn, sclk, sdo;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [1:0]       sym_a [SLOTS];
  logic [NBITS-1:0] exp_cap;
  logic             exp_cnt, exp_pos;
  logic [NBITS-1:0] rx_bits;
  int               rx_n = 0;
  int               since_rise = 0;
  logic             prev_sclk = 1'b0, prev_sdo = 1'b0;

  tcf_readout #(.FRAME_SLOTS(SLOTS), .CLK_DIV_HALF(HALF)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sym_valid_i (sym_valid),
    .sym_i       (sym),
    .ready_o     (ready),
    .cnt_ok_o    (cnt_ok),
    .pos_ok_o    (pos_ok),
    .spi_csn_o   (csn),
    .spi_sclk_o  (sclk),
    .spi_sdo_o   (sdo)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic logic mslot(input int s);
    return (s == 0) || (s % 10 == 9);
  endfunction

  function automatic int mark_at(input int i);
    return (i == 0) ? 0 : i * 10 - 1;
  endfunction

  // serial monitor, sampled away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (csn && (sclk || sdo)) chk(1'b0, "R6 idle quiet", {sclk, sdo}, 0);
      if (sclk && prev_sclk && sdo != prev_sdo) chk(1'b0, "R5 sdo moved while sclk high", sdo, prev_sdo);
      since_rise++;
      if (sclk && !prev_sclk) begin
        if (csn) chk(1'b0, "R6 rise outside select", csn, 0);
        if (rx_n > 0 && rx_n < NBITS) chk(since_rise == 2 * HALF, "R5 sclk period", since_rise, 2 * HALF);
        if (rx_n < NBITS) rx_bits[rx_n] = sdo;
        rx_n++;
        since_rise = 0;
      end
    end
    prev_sclk = sclk;
    prev_sdo  = sdo;
  end

  task automatic build(input int mode);
    int s, k;
    for (int i = 0; i < SLOTS; i++) begin
      if (mslot(i)) sym_a[i] = 2'd2;
      else case (mode)
        4:       sym_a[i] = 2'd1;
        6:       sym_a[i] = 2'd0;
        5:       sym_a[i] = 2'(($urandom % 2) ? 3 : ($urandom % 2));
        default: sym_a[i] = 2'($urandom % 2);
      endcase
    end
    k = int'($urandom % 7);
    do s = int'($urandom % SLOTS); while (mslot(s));
    if (mode == 1) sym_a[mark_at(k)] = 2'd0;
    if (mode == 2) begin sym_a[mark_at(k)] = 2'd1; sym_a[s] = 2'd2; end
    if (mode == 3) sym_a[s] = 2'd2;
    k = 0;
    exp_pos = 1'b1;
    s = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (sym_a[i] == 2'd2) s++;
      if ((sym_a[i] == 2'd2) != mslot(i)) exp_pos = 1'b0;
      if (!mslot(i)) begin exp_cap[k] = (sym_a[i] == 2'd1); k++; end
    end
    exp_cnt = (s == 7);
  endtask

  task automatic run_frame(input int mode, input bit junk);
    logic [NBITS-1:0] exp_ser;
    build(mode);
    rx_n = 0;
    for (int i = 0; i < SLOTS; i++) begin
      repeat (int'($urandom % 3)) @(negedge clk);
      @(negedge clk);
      if (i == SLOTS - 1) chk(!ready, "R3 ready low before last symbol", ready, 0);
      sym_valid = 1'b1;
      sym = sym_a[i];
      @(negedge clk);
      sym_valid = 1'b0;
      sym = 2'($urandom);
    end
    chk(ready, "R3 ready on last symbol", ready, 1);
    chk(!csn, "R6 select falls on last symbol", csn, 0);
    chk(cnt_ok == exp_cnt, "R7 count flag", cnt_ok, exp_cnt);
    chk(pos_ok == exp_pos, "R8 position flag", pos_ok, exp_pos);
    while (ready) begin
      if (!csn == 1'b0) chk(1'b0, "R3 select high while ready", csn, 0);
      if (junk) begin
        sym_valid = $urandom % 2;
        sym = 2'(($urandom % 3 == 0) ? 2 : $urandom);
      end
      @(negedge clk);
    end
    sym_valid = 1'b0;
    chk(csn, "R3 ready falls with select", csn, 1);
    chk(rx_n == NBITS, "R6 rising edge count", rx_n, NBITS);
    for (int j = 0; j < NBITS; j++) exp_ser[j] = exp_cap[NBITS - 1 - j];
    chk(rx_bits == exp_ser, "R4 reversed stream (R2 capture)", rx_bits, exp_ser);
    repeat (5) @(negedge clk);
    chk(cnt_ok == exp_cnt && pos_ok == exp_pos, "R7 R8 flags held", {cnt_ok, pos_ok}, {exp_cnt, exp_pos});
    chk(!ready && csn && !sclk, "R5 R6 idle after transfer", {ready, csn, sclk}, 3'b010);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!ready && csn && !sclk && !sdo && !cnt_ok && !pos_ok, "R1 reset state",
        {ready, csn, sclk, sdo, cnt_ok, pos_ok}, 6'b010000);
    rst_n = 1'b1;
    // junk during reset-free idle is not a pending frame: only valid strobes count
    repeat (4) @(negedge clk);
    chk(!ready && csn, "R2 no strobe no capture", {ready, csn}, 2'b01);
    run_frame(0, 1'b0);
    run_frame(4, 1'b1);
    run_frame(6, 1'b0);
    run_frame(5, 1'b1);
    run_frame(1, 1'b0);
    run_frame(2, 1'b1);
    run_frame(3, 1'b0);
    run_frame(0, 1'b1);  // R9: junk above must not leak into this minute
    for (int n = 0; n < 6; n++) run_frame(int'($urandom % 7), 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule